// File: doc/BRIEF.md
# Paged Virtual-Address Translator

This block sits between a processor and a single-ported word memory and turns virtual word addresses into physical ones through a page table that lives in that same memory. On every processor reference it splits the virtual address into a page number and a word offset. It reads the table entry found at the base register plus the page number and looks at the entry's residency flag.

If the page is resident, the block writes the entry back with its usage flags updated, so that software can later choose a least-recently-used victim. It then performs the data access at the physical address built from the entry's frame number and the unchanged offset. If the page is not resident, no data access and no entry update take place. The block instead raises a one-cycle fault that carries the page number and the storage locator held in the entry.

The page size is fixed at build time to 512 or 1024 words. The table base is loaded through a small configuration port.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `cpu_done`, `cpu_fault` and `mem_req` are low and the block waits for a request.
- R2: A request pulse on `cpu_req` starts a walk whose first memory operation is a read at address `base + page`, where `page` is the virtual address bits above the offset (offset is 9 bits for 512-word pages, 10 bits for 1024-word pages).
- R3: A table entry is DW bits wide. Bit DW-1 is the resident flag, bit DW-2 the referenced flag and bit DW-3 the modified flag. The low PA_W-offset bits hold the frame number when resident and a storage locator when not.
- R4: For a resident page the data access goes to `{frame, offset}`. A read returns the word on `cpu_rdata` in the cycle `cpu_done` is high. A write stores `cpu_wdata` there.
- R5: For a non-resident page, `cpu_fault` pulses for one cycle with `fault_page` equal to the page number and `fault_loc` equal to the entry's low field. Exactly one memory operation (the entry read) occurs and the entry is left unchanged.
- R6: A resident reference performs exactly three memory operations in order: entry read, entry write, data access. The entry is written back with the referenced flag set and the modified flag set on a write, and with all other bits preserved.
- R7: `cfg_we` loads `cfg_base` into the table base register. A walk uses the base value held when its request was accepted, even if the base changes mid-walk.
- R8: The last word of a page (offset all ones) and the last page (page number all ones) translate without spilling into neighbouring frames or entries.
- R9: Once raised, `mem_req` stays high with a stable address until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the table base register |
| cfg_base | input | PA_W | New table base address |
| cpu_req | input | 1 | One-cycle reference request, accepted when idle |
| cpu_we | input | 1 | Reference is a write |
| cpu_vaddr | input | VA_W | Virtual word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Reference completed |
| cpu_fault | output | 1 | Page not resident |
| fault_page | output | VA_W-OFF | Faulting page number |
| fault_loc | output | PA_W-OFF | Storage locator from the faulting entry |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | Memory operation is a write |
| mem_addr | output | PA_W | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory operation complete |

## Verification
The bench builds the block with its defaults: 16-bit virtual addresses, 18-bit physical addresses, 16-bit words and 512-word pages. That gives a 9-bit offset, a 7-bit page number and a 9-bit frame field. With these values the last offset 0x1FF and the last page 127 can be reached directly, so R8 is tested at its real boundaries. The small page count also lets one bench memory hold two complete page tables next to several data frames, so the switch of base register mid-walk can be observed from the data that comes back.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W       = 16,
  parameter int PA_W       = 18,
  parameter int DW         = 16,
  parameter int PAGE_WORDS = 512
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [PA_W-1:0]                   cfg_base,
  input  logic                              cpu_req,
  input  logic                              cpu_we,
  input  logic [VA_W-1:0]                   cpu_vaddr,
  input  logic [DW-1:0]                     cpu_wdata,
  output logic [DW-1:0]                     cpu_rdata,
  output logic                              cpu_done,
  output logic                              cpu_fault,
  output logic [VA_W-$clog2(PAGE_WORDS)-1:0] fault_page,
  output logic [PA_W-$clog2(PAGE_WORDS)-1:0] fault_loc,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [PA_W-1:0]                   mem_addr,
  output logic [DW-1:0]                     mem_wdata,
  input  logic [DW-1:0]                     mem_rdata,
  input  logic                              mem_ack
);
  localparam int OFF_W = $clog2(PAGE_WORDS);
  localparam int PN_W  = VA_W - OFF_W;
  localparam int FR_W  = PA_W - OFF_W;
  localparam int RES_B = DW - 1;
  localparam int REF_B = DW - 2;
  localparam int MOD_B = DW - 3;

  initial begin
    if (PAGE_WORDS != 512 && PAGE_WORDS != 1024) $error("page size must be 512 or 1024");
    if (FR_W > MOD_B) $error("frame field overlaps flags");
    if (PN_W >= PA_W) $error("page number wider than physical address");
  end

  typedef enum logic [2:0] {
    S_IDLE, S_RDPTE, S_CHECK, S_WRPTE, S_ACCESS, S_DONE, S_FAULT
  } state_t;

  state_t            state;
  logic [PA_W-1:0]   base_q;
  logic [PA_W-1:0]   pte_addr_q;
  logic [PN_W-1:0]   pn_q;
  logic [OFF_W-1:0]  off_q;
  logic              we_q;
  logic [DW-1:0]     wd_q;
  logic [DW-1:0]     pte_q;
  logic [DW-1:0]     rdata_q;
  logic [FR_W-1:0]   floc_q;
  logic [DW-1:0]     pte_upd;

  wire [PN_W-1:0]  req_pn  = cpu_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] req_off = cpu_vaddr[OFF_W-1:0];

  always_comb begin
    pte_upd        = pte_q;
    pte_upd[REF_B] = 1'b1;
    if (we_q) pte_upd[MOD_B] = 1'b1;
  end

  assign mem_req   = (state == S_RDPTE) || (state == S_WRPTE) || (state == S_ACCESS);
  assign mem_we    = (state == S_WRPTE) || ((state == S_ACCESS) && we_q);
  assign mem_addr  = (state == S_ACCESS) ? {pte_q[FR_W-1:0], off_q} : pte_addr_q;
  assign mem_wdata = (state == S_WRPTE) ? pte_upd : wd_q;
  assign cpu_done  = (state == S_DONE);
  assign cpu_fault = (state == S_FAULT);
  assign cpu_rdata = rdata_q;
  assign fault_page = pn_q;
  assign fault_loc  = floc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pte_addr_q <= '0;
      pn_q       <= '0;
      off_q      <= '0;
      we_q       <= 1'b0;
      wd_q       <= '0;
      pte_q      <= '0;
      rdata_q    <= '0;
      floc_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          pte_addr_q <= base_q + {{(PA_W-PN_W){1'b0}}, req_pn};
          pn_q       <= req_pn;
          off_q      <= req_off;
          we_q       <= cpu_we;
          wd_q       <= cpu_wdata;
          state      <= S_RDPTE;
        end
        S_RDPTE: if (mem_ack) begin
          pte_q <= mem_rdata;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (pte_q[RES_B]) begin
            state <= S_WRPTE;
          end else begin
            floc_q <= pte_q[FR_W-1:0];
            state  <= S_FAULT;
          end
        end
        S_WRPTE:  if (mem_ack) state <= S_ACCESS;
        S_ACCESS: if (mem_ack) begin
          if (!we_q) rdata_q <= mem_rdata;
          state <= S_DONE;
        end
        S_DONE:   state <= S_IDLE;
        S_FAULT:  state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  a_r2_walk_starts_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_req) |=> (mem_req && !mem_we));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_fault_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fault |-> ($past(state) == S_CHECK && !$past(pte_q[RES_B])));

  a_r6_update_marks_referenced: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state == S_WRPTE) |-> (mem_wdata[REF_B] && mem_wdata[RES_B]));

  a_r4_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> ($past(state) == S_ACCESS && $past(mem_ack)));

  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_done, cpu_fault, mem_req}));
endmodule

// File: tb/sim_pt_xlate.sv
module sim_pt_xlate;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        cfg_we = 0;
  logic [17:0] cfg_base = '0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_vaddr = '0, cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_done, cpu_fault;
  logic [6:0]  fault_page;
  logic [8:0]  fault_loc;
  logic        mem_req, mem_we, mem_ack;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  pt_xlate u0 (.*);

  logic [15:0] mem [4096];
  int ops = 0;
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else begin
      mem_ack <= mem_req & ~mem_ack;
      if (mem_req && !mem_ack) begin
        ops <= ops + 1;
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[11:0]];
      end
    end
  end

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic got_done, got_fault;
  logic [15:0] got_rdata;
  logic [6:0]  got_page;
  logic [8:0]  got_loc;
  int          ops0;

  task automatic wait_end();
    got_done = 0; got_fault = 0;
    for (int i = 0; i < 60 && !got_done && !got_fault; i++) begin
      @(negedge clk);
      got_done = cpu_done; got_fault = cpu_fault;
      got_rdata = cpu_rdata; got_page = fault_page; got_loc = fault_loc;
    end
  endtask

  task automatic do_ref(input logic we, input logic [15:0] va, input logic [15:0] wd);
    @(negedge clk);
    ops0 = ops;
    cpu_req = 1; cpu_we = we; cpu_vaddr = va; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    wait_end();
  endtask

  // we | va | wdata | fault | expected (read data, stored data or locator) | physical address
  localparam logic [61:0] VEC [6] = '{
    {1'b1, 16'h0005, 16'hA5A5, 1'b0, 16'hA5A5, 12'h205},
    {1'b0, 16'h0005, 16'h0000, 1'b0, 16'hA5A5, 12'h205},
    {1'b0, 16'h03FF, 16'h0000, 1'b0, 16'h1234, 12'h7FF},
    {1'b0, 16'h0410, 16'h0000, 1'b1, 16'h0055, 12'h000},
    {1'b1, 16'h0A00, 16'hBEEF, 1'b0, 16'hBEEF, 12'h800},
    {1'b0, 16'hFE03, 16'h0000, 1'b1, 16'h0000, 12'h000}
  };
  // expected entry value after each vector (R3/R6 flags: bit15 resident, bit14 referenced, bit13 modified)
  localparam logic [15:0] PTE_AFTER [6] = '{16'hE001, 16'hE001, 16'hC003, 16'h0055, 16'hE004, 16'h0000};

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'hC00] = 16'h8001;
    mem[12'hC01] = 16'h8003;
    mem[12'hC02] = 16'h0055;
    mem[12'hC05] = 16'h8004;
    mem[12'hD00] = 16'h8002;
    mem[12'h7FF] = 16'h1234;
    mem[12'h405] = 16'h7777;
    mem[12'h800] = 16'h5A5A;

    repeat (3) @(negedge clk);
    chk("R1 done low in reset", cpu_done, 0);
    chk("R1 fault low in reset", cpu_fault, 0);
    chk("R1 mem_req low in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", mem_req, 0);

    cfg_we = 1; cfg_base = 18'h00C00;
    @(negedge clk);
    cfg_we = 0;

    for (int v = 0; v < 6; v++) begin
      logic [61:0] e;
      logic [6:0]  pn;
      e = VEC[v];
      pn = e[60:54];
      do_ref(e[61], e[60:45], e[44:29]);
      if (e[28]) begin
        chk($sformatf("R5 fault flag v%0d", v), got_fault, 1);
        chk($sformatf("R5 fault page v%0d", v), got_page, pn);
        chk($sformatf("R5 fault locator v%0d", v), got_loc, e[24:12]);
        chk($sformatf("R5 single op v%0d", v), ops - ops0, 1);
      end else begin
        chk($sformatf("R4 done v%0d", v), got_done, 1);
        chk($sformatf("R6 three ops v%0d", v), ops - ops0, 3);
        if (e[61]) chk($sformatf("R4 stored word v%0d", v), mem[e[11:0]], e[27:12]);
        else       chk($sformatf("R4 R8 read word v%0d", v), got_rdata, e[27:12]);
      end
      chk($sformatf("R2 R6 entry flags v%0d", v), mem[12'hC00 + 12'(pn)], PTE_AFTER[v]);
    end
    chk("R8 next frame untouched", mem[12'h800], 16'hBEEF);
    chk("R8 neighbour entry untouched", mem[12'hC7E], 16'h0000);

    // R7: base changed during a walk; walk keeps old base
    @(negedge clk);
    ops0 = ops;
    cpu_req = 1; cpu_we = 0; cpu_vaddr = 16'h03FF;
    @(negedge clk);
    cpu_req = 0; cfg_we = 1; cfg_base = 18'h00D00;
    @(negedge clk);
    cfg_we = 0;
    wait_end();
    chk("R7 walk used old base", {got_done, got_rdata}, {1'b1, 16'h1234});

    // R7: new base now used
    do_ref(1'b0, 16'h0005, 16'h0);
    chk("R7 new table read", got_rdata, 16'h7777);
    chk("R7 new table entry updated", mem[12'hD00], 16'hC002);
    do_ref(1'b0, 16'h0205, 16'h0);
    chk("R7 R5 absent in new table", {got_fault, 9'(got_page)}, {1'b1, 9'd1});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule